// File: doc/BRIEF.md
# Event Status and Mask Interrupt Aggregator

This block gathers 96 single-bit hardware event lines into three shared 32-bit sticky status words. Three independent mask groups each hold one enable word per status word. Each group combines the status words with its own enables and drives one level-sensitive interrupt line. A processor services a line in three steps: it reads that group's vector register to learn the lowest-numbered pending enabled event, handles the event, and writes a one back to the event's status bit to clear it.

Software reaches every register through a plain synchronous register port. A read request is answered one clock later with a valid strobe, and that answer cannot be stalled. Writes take effect at the clock edge on which they are presented. The interrupt lines are registered. A status or mask change therefore shows on a line one clock after the change has landed in its register.

Addresses are byte addresses on 32-bit words, and an address whose two low bits are not zero is unmapped. Status word w is at 4·w. Group g's enable word for status word w is at 0x10·(g+1) + 4·w. Group g's vector register is at 0x40 + 4·g.

Top module: `evt_irq_agg`

## Requirements
- R1: After reset every status and enable word reads 0, every vector register reads 0, all three interrupt lines are low and the read valid strobe is low.
- R2: An event line that is high at a clock edge sets bit (e mod 32) of status word (e div 32). The bit stays set after the line drops, until software clears it.
- R3: A write to status word w clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R4: When an event line is high in the same cycle as a clearing write to its bit, the bit is set after that edge.
- R5: Enable words are read/write at 0x10·(g+1) + 4·w for groups g = 0..2 and words w = 0..2, and each reads back the value last written to it.
- R6: Interrupt line g is high exactly one clock after some status bit is 1 while group g's enable bit for that position is also 1. It is low one clock after no such bit remains, whether a status clear or an enable change caused that.
- R7: The vector register of group g returns bit 31 = 1 and bits [6:0] = the lowest global event number (word·32 + bit) that is pending and enabled in group g, with all other bits 0. It returns 0 when no such event exists.
- R8: The groups are independent: an event enabled only in group g raises only line g, and only group g's vector reports it.
- R9: Reads of unmapped or misaligned addresses return 0. Writes to vector registers, to unmapped addresses or to misaligned addresses change no register.
- R10: A read request is answered on the next clock with the read valid strobe high for one cycle. The strobe is low in every cycle that does not follow a read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 96 | Event lines, sampled each clock; a high level sets the status bit |
| bus_rd_i | input | 1 | Read request for `bus_addr_i` |
| bus_wr_i | input | 1 | Write request of `bus_wdata_i` to `bus_addr_i` |
| bus_addr_i | input | 8 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid with `bus_rvalid_o` |
| bus_rvalid_o | output | 1 | High the cycle after a read request |
| irq_o | output | 3 | Interrupt line per mask group |

## Verification
A sweep raises each of the 96 events on its own. The event is first left masked, so the test can tell a status bit apart from an interrupt. It is then enabled in a group picked by the event number, which shows that the right line and no other rises one cycle later and that the vector names the event in that group only. Pairs of simultaneous events at word borders and word ends check lowest-first priority, with the higher event reported after the lower one is cleared. Separate patterns cover partial clear masks, an event arriving together with its own clear, distinct enable patterns in all nine enable words, and accesses to vector, unmapped and misaligned addresses.

// File: rtl/evt_pkg.sv
package evt_pkg;
  localparam int unsigned BUS_AW           = 8;
  localparam int unsigned GRP_STRIDE_WORDS = 4;
  localparam int unsigned VEC_BASE_WORD    = 16;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_STAT = 2'd1,
    SEL_MASK = 2'd2,
    SEL_VEC  = 2'd3
  } sel_e;

  typedef struct packed {
    sel_e       kind;
    logic [3:0] grp;
    logic [3:0] word;
  } dec_t;

  function automatic dec_t addr_decode(input logic [BUS_AW-1:0] a,
                                       input int unsigned nw,
                                       input int unsigned ng);
    dec_t        d;
    int unsigned wa;
    d.kind = SEL_NONE;
    d.grp  = '0;
    d.word = '0;
    wa = 32'(a[BUS_AW-1:2]);
    if (a[1:0] == 2'b00) begin
      if (wa < nw) begin
        d.kind = SEL_STAT;
        d.word = 4'(wa);
      end else if (wa >= VEC_BASE_WORD && wa < VEC_BASE_WORD + ng) begin
        d.kind = SEL_VEC;
        d.grp  = 4'(wa - VEC_BASE_WORD);
      end else if (wa >= GRP_STRIDE_WORDS && wa < VEC_BASE_WORD) begin
        if ((wa % GRP_STRIDE_WORDS) < nw &&
            (wa / GRP_STRIDE_WORDS) - 1 < ng) begin
          d.kind = SEL_MASK;
          d.grp  = 4'((wa / GRP_STRIDE_WORDS) - 1);
          d.word = 4'(wa % GRP_STRIDE_WORDS);
        end
      end
    end
    return d;
  endfunction
endpackage

// File: rtl/evt_lowest_enc.sv
module evt_lowest_enc #(
  parameter int unsigned N  = 96,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]  vec_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) begin
        found_o = 1'b1;
        idx_o   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/evt_status_bank.sv
module evt_status_bank #(
  parameter int unsigned N_WORDS = 3,
  parameter int unsigned WORD_W  = 32,
  localparam int unsigned N      = N_WORDS * WORD_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N-1:0]       evt_i,
  input  logic [N_WORDS-1:0] clr_we_i,
  input  logic [WORD_W-1:0]  clr_data_i,
  output logic [N-1:0]       stat_o
);
  logic [WORD_W-1:0] word_q [N_WORDS];

  for (genvar w = 0; w < N_WORDS; w++) begin : g_word
    logic [WORD_W-1:0] clr_bits;
    assign clr_bits = clr_we_i[w] ? clr_data_i : '0;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) word_q[w] <= '0;
      else        word_q[w] <= (word_q[w] & ~clr_bits) | evt_i[w*WORD_W +: WORD_W];
    end

    assign stat_o[w*WORD_W +: WORD_W] = word_q[w];
  end
endmodule

// File: rtl/evt_mask_group.sv
module evt_mask_group #(
  parameter int unsigned N_WORDS = 3,
  parameter int unsigned WORD_W  = 32,
  localparam int unsigned N      = N_WORDS * WORD_W,
  localparam int unsigned IW     = $clog2(N)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N-1:0]       stat_i,
  input  logic [N_WORDS-1:0] we_i,
  input  logic [WORD_W-1:0]  wdata_i,
  output logic [N-1:0]       mask_o,
  output logic               found_o,
  output logic [WORD_W-1:0]  vec_o,
  output logic               irq_o
);
  logic [WORD_W-1:0] en_q [N_WORDS];
  logic [N-1:0]      pend;
  logic [IW-1:0]     idx;
  logic              irq_q;

  for (genvar w = 0; w < N_WORDS; w++) begin : g_en
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     en_q[w] <= '0;
      else if (we_i[w]) en_q[w] <= wdata_i;
    end
    assign mask_o[w*WORD_W +: WORD_W] = en_q[w];
  end

  assign pend = stat_i & mask_o;

  evt_lowest_enc #(.N(N)) u_enc (
    .vec_i   (pend),
    .found_o (found_o),
    .idx_o   (idx)
  );

  always_comb begin
    vec_o             = '0;
    vec_o[IW-1:0]     = idx;
    vec_o[WORD_W-1]   = found_o;
    if (!found_o) vec_o = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |pend;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/evt_irq_agg.sv
module evt_irq_agg
  import evt_pkg::*;
#(
  parameter int unsigned N_WORDS = 3,
  parameter int unsigned WORD_W  = 32,
  parameter int unsigned N_GRP   = 3,
  localparam int unsigned N      = N_WORDS * WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      evt_i,
  input  logic              bus_rd_i,
  input  logic              bus_wr_i,
  input  logic [BUS_AW-1:0] bus_addr_i,
  input  logic [WORD_W-1:0] bus_wdata_i,
  output logic [WORD_W-1:0] bus_rdata_o,
  output logic              bus_rvalid_o,
  output logic [N_GRP-1:0]  irq_o
);
  dec_t               dec;
  logic [N-1:0]       stat_flat;
  logic [N_WORDS-1:0] stat_clr_we;
  logic [N-1:0]       mask_flat [N_GRP];
  logic [WORD_W-1:0]  vec_word  [N_GRP];
  logic [N_GRP-1:0]   enc_found;
  logic [WORD_W-1:0]  rd_mux;
  logic [WORD_W-1:0]  rdata_q;
  logic               rvalid_q;

  assign dec = addr_decode(bus_addr_i, N_WORDS, N_GRP);

  for (genvar w = 0; w < N_WORDS; w++) begin : g_clr
    assign stat_clr_we[w] = bus_wr_i && dec.kind == SEL_STAT && dec.word == 4'(w);
  end

  evt_status_bank #(.N_WORDS(N_WORDS), .WORD_W(WORD_W)) u_stat (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_i      (evt_i),
    .clr_we_i   (stat_clr_we),
    .clr_data_i (bus_wdata_i),
    .stat_o     (stat_flat)
  );

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    logic [N_WORDS-1:0] en_we;
    for (genvar w = 0; w < N_WORDS; w++) begin : g_we
      assign en_we[w] = bus_wr_i && dec.kind == SEL_MASK &&
                        dec.grp == 4'(g) && dec.word == 4'(w);
    end

    evt_mask_group #(.N_WORDS(N_WORDS), .WORD_W(WORD_W)) u_grp (
      .clk     (clk),
      .rst_n   (rst_n),
      .stat_i  (stat_flat),
      .we_i    (en_we),
      .wdata_i (bus_wdata_i),
      .mask_o  (mask_flat[g]),
      .found_o (enc_found[g]),
      .vec_o   (vec_word[g]),
      .irq_o   (irq_o[g])
    );
  end

  always_comb begin
    rd_mux = '0;
    case (dec.kind)
      SEL_STAT: begin
        for (int w = 0; w < int'(N_WORDS); w++)
          if (dec.word == 4'(w)) rd_mux = stat_flat[w*WORD_W +: WORD_W];
      end
      SEL_MASK: begin
        for (int g = 0; g < int'(N_GRP); g++)
          for (int w = 0; w < int'(N_WORDS); w++)
            if (dec.grp == 4'(g) && dec.word == 4'(w))
              rd_mux = mask_flat[g][w*WORD_W +: WORD_W];
      end
      SEL_VEC: begin
        for (int g = 0; g < int'(N_GRP); g++)
          if (dec.grp == 4'(g)) rd_mux = vec_word[g];
      end
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= bus_rd_i;
      rdata_q  <= bus_rd_i ? rd_mux : '0;
    end
  end

  assign bus_rdata_o  = rdata_q;
  assign bus_rvalid_o = rvalid_q;
endmodule

// File: rtl/evt_irq_agg_chk.sv
module evt_irq_agg_chk #(
  parameter int unsigned N_WORDS = 3,
  parameter int unsigned WORD_W  = 32,
  parameter int unsigned N_GRP   = 3,
  localparam int unsigned N      = N_WORDS * WORD_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N-1:0]      evt_i,
  input logic              bus_rd_i,
  input logic              bus_wr_i,
  input logic [7:0]        bus_addr_i,
  input logic [WORD_W-1:0] bus_rdata_o,
  input logic              bus_rvalid_o,
  input logic [N_GRP-1:0]  irq_o,
  input logic [N-1:0]      stat_q,
  input logic [N_GRP-1:0]  enc_found
);
  logic was_rst;

  always @(posedge clk) begin
    if (was_rst) begin
      a_r1_reset_quiet: assert (irq_o == '0 && stat_q == '0 && !bus_rvalid_o);
    end
    was_rst <= !rst_n;
  end

  a_r10_read_answered: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd_i |=> bus_rvalid_o);

  a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd_i |=> !bus_rvalid_o);

  a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr_i && bus_addr_i < 8'(4 * N_WORDS))
      |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

  a_r4_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_q & $past(evt_i)) == $past(evt_i)));

  a_r9_misaligned_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd_i && bus_addr_i[1:0] != 2'b00) |=> bus_rdata_o == '0);

  a_r7_vec_form: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd_i && bus_addr_i == 8'h40)
      |=> (bus_rdata_o[WORD_W-1] || bus_rdata_o == '0));

  for (genvar g = 0; g < N_GRP; g++) begin : g_irq
    a_r6_irq_tracks: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> irq_o[g] == $past(enc_found[g]));
  end
endmodule

bind evt_irq_agg evt_irq_agg_chk #(
  .N_WORDS(N_WORDS), .WORD_W(WORD_W), .N_GRP(N_GRP)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .evt_i        (evt_i),
  .bus_rd_i     (bus_rd_i),
  .bus_wr_i     (bus_wr_i),
  .bus_addr_i   (bus_addr_i),
  .bus_rdata_o  (bus_rdata_o),
  .bus_rvalid_o (bus_rvalid_o),
  .irq_o        (irq_o),
  .stat_q       (stat_flat),
  .enc_found    (enc_found)
);

// File: tb/evt_irq_agg_bench.sv
module evt_irq_agg_bench;
  localparam int NW = 3;
  localparam int NG = 3;
  localparam int NE = 96;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NE-1:0] evt;
  logic          rd, wr;
  logic [7:0]    addr;
  logic [31:0]   wdata, rdata;
  logic          rvalid;
  logic [2:0]    irq;
  int            total = 0;
  int            bad = 0;
  bit            finished = 1'b0;

  always #5 clk = ~clk;

  evt_irq_agg u_evt_irq_agg (
    .clk(clk), .rst_n(rst_n), .evt_i(evt),
    .bus_rd_i(rd), .bus_wr_i(wr), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .bus_rvalid_o(rvalid), .irq_o(irq)
  );

  function automatic logic [7:0] stat_a(input int w);
    return 8'(4 * w);
  endfunction
  function automatic logic [7:0] mask_a(input int g, input int w);
    return 8'(16 * (g + 1) + 4 * w);
  endfunction
  function automatic logic [7:0] vec_a(input int g);
    return 8'(64 + 4 * g);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    addr = a; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    chk("R10 valid", {31'b0, rvalid}, 32'd1);
    chk(req, rdata, exp);
  endtask

  task automatic pulse(input logic [NE-1:0] v);
    evt = v;
    @(negedge clk);
    evt = '0;
  endtask

  task automatic summary;
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; evt = '0; rd = 1'b0; wr = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk("R1 irq", {29'b0, irq}, 32'd0);
    chk("R1 rvalid", {31'b0, rvalid}, 32'd0);
    for (int w = 0; w < NW; w++) begin
      rd_chk("R1 status", stat_a(w), 32'd0);
      for (int g = 0; g < NG; g++) rd_chk("R1 mask", mask_a(g, w), 32'd0);
    end
    for (int g = 0; g < NG; g++) rd_chk("R1 vector", vec_a(g), 32'd0);
    @(negedge clk);
    chk("R10 idle", {31'b0, rvalid}, 32'd0);

    // R2 R6 R7 R8 R3: every event alone
    for (int e = 0; e < NE; e++) begin
      automatic int w = e / 32;
      automatic int b = e % 32;
      automatic int g = e % NG;
      automatic logic [NE-1:0] one = '0;
      one[e] = 1'b1;
      pulse(one);
      @(negedge clk);
      chk("R6 masked", {29'b0, irq}, 32'd0);
      rd_chk("R2 sticky", stat_a(w), 32'd1 << b);
      rd_chk("R7 none", vec_a(g), 32'd0);
      wr_reg(mask_a(g, w), 32'd1 << b);
      @(negedge clk);
      chk("R6 R8 irq", {29'b0, irq}, 32'(1 << g));
      rd_chk("R7 vec", vec_a(g), 32'h8000_0000 | 32'(e));
      rd_chk("R8 other", vec_a((g + 1) % NG), 32'd0);
      wr_reg(stat_a(w), 32'd1 << b);
      @(negedge clk);
      chk("R6 drop", {29'b0, irq}, 32'd0);
      rd_chk("R3 clear", stat_a(w), 32'd0);
      wr_reg(mask_a(g, w), 32'd0);
    end

    // R7 priority with group 1 fully enabled
    for (int w = 0; w < NW; w++) wr_reg(mask_a(1, w), 32'hFFFF_FFFF);
    begin
      automatic int lo_l[6] = '{0, 5, 31, 32, 63, 70};
      automatic int hi_l[6] = '{1, 31, 32, 72, 64, 95};
      for (int p = 0; p < 6; p++) begin
        automatic logic [NE-1:0] two = '0;
        two[lo_l[p]] = 1'b1;
        two[hi_l[p]] = 1'b1;
        pulse(two);
        rd_chk("R7 lowest", vec_a(1), 32'h8000_0000 | 32'(lo_l[p]));
        chk("R6 pair irq", {29'b0, irq}, 32'd2);
        wr_reg(stat_a(lo_l[p] / 32), 32'd1 << (lo_l[p] % 32));
        rd_chk("R7 next", vec_a(1), 32'h8000_0000 | 32'(hi_l[p]));
        wr_reg(stat_a(hi_l[p] / 32), 32'd1 << (hi_l[p] % 32));
        rd_chk("R7 empty", vec_a(1), 32'd0);
      end
    end
    for (int w = 0; w < NW; w++) wr_reg(mask_a(1, w), 32'd0);

    // R3: partial clear and zero write
    pulse((NE'(1) << 3) | (NE'(1) << 7));
    wr_reg(stat_a(0), 32'd0);
    rd_chk("R3 zero write", stat_a(0), 32'h0000_0088);
    wr_reg(stat_a(0), 32'h0000_0008);
    rd_chk("R3 partial", stat_a(0), 32'h0000_0080);
    wr_reg(stat_a(0), 32'hFFFF_FFFF);
    rd_chk("R3 all", stat_a(0), 32'd0);

    // R4: event together with its clear
    evt = NE'(1) << 40;
    wr_reg(stat_a(1), 32'h0000_0100);
    evt = '0;
    rd_chk("R4 set wins", stat_a(1), 32'h0000_0100);
    wr_reg(stat_a(1), 32'h0000_0100);
    rd_chk("R4 cleared", stat_a(1), 32'd0);

    // R5: distinct patterns in all enable words
    for (int g = 0; g < NG; g++)
      for (int w = 0; w < NW; w++)
        wr_reg(mask_a(g, w), 32'h5A00_0000 ^ (32'(g * 4 + w + 1) * 32'h0001_0101));
    for (int g = 0; g < NG; g++)
      for (int w = 0; w < NW; w++)
        rd_chk("R5 readback", mask_a(g, w), 32'h5A00_0000 ^ (32'(g * 4 + w + 1) * 32'h0001_0101));

    // R9: unmapped reads and ignored writes
    rd_chk("R9 gap", 8'h0C, 32'd0);
    rd_chk("R9 group gap", 8'h1C, 32'd0);
    rd_chk("R9 past vectors", 8'h4C, 32'd0);
    rd_chk("R9 misaligned", 8'h11, 32'd0);
    rd_chk("R9 top", 8'hFC, 32'd0);
    wr_reg(8'h40, 32'hFFFF_FFFF);
    wr_reg(8'h0C, 32'hFFFF_FFFF);
    wr_reg(8'h12, 32'hFFFF_FFFF);
    wr_reg(8'h01, 32'hFFFF_FFFF);
    for (int g = 0; g < NG; g++)
      for (int w = 0; w < NW; w++)
        rd_chk("R9 masks kept", mask_a(g, w), 32'h5A00_0000 ^ (32'(g * 4 + w + 1) * 32'h0001_0101));
    for (int g = 0; g < NG; g++) rd_chk("R9 vector kept", vec_a(g), 32'd0);
    chk("R9 irq", {29'b0, irq}, 32'd0);

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule